// File: doc/BRIEF.md
# CPU Exception Acceptance Prioritizer

This block decides which pending exception a small CPU core takes and in which cycle it takes it. It watches two reset sources: the rising edge of an already synchronized, active-low reset pin and a single-cycle watchdog overflow pulse. It also watches a trace flag and the interrupt control mode, an interrupt request that the interrupt controller has already masked, an end-of-instruction strobe that carries the class of the instruction that just retired, a trap-execute strobe and an end-of-handling strobe. When it accepts an exception it raises a one-cycle start pulse. With that pulse it gives a one-hot exception type and the vector number that the fetch unit uses to read the start address from the vector table.

The decision follows a fixed ranking. The reset sources are examined on every clock and cut short any handling that is under way. The trace and interrupt sources are examined only at a boundary. That boundary is the end of an instruction while the core runs code, or the end of a handling sequence while one is in progress. Some instructions and events close the window for certain sources. An instruction that writes the control flags blocks interrupts at its end. A return-from-exception instruction blocks trace at its end. The end of reset handling blocks interrupts. Trace exists only in interrupt control mode 2. A trap is taken when the trap instruction executes and the core is running code.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `start_o` is 0, `accept_o` is 0 and `busy_o` is 0.
- R2: A low-to-high change of `rst_pin_i` or a high `wdt_ovf_i` in cycle N gives `start_o`=1, `accept_o`=4'b0001 and `vec_o`=0 in cycle N+1. This happens whether or not handling is in progress and whether or not a boundary is present.
- R3: The ranking from highest to lowest is reset (bit 0), trace (bit 1), interrupt (bit 2), trap (bit 3) in `accept_o`. When `start_o` is 1, exactly one bit of `accept_o` is set. When `start_o` is 0, `accept_o` is 0.
- R4: Trace and interrupt are accepted only in a cycle that has `instr_end_i`=1 with `busy_o`=0, or `seq_end_i`=1 with `busy_o`=1.
- R5: Trace (vector 5) is accepted only when `int_mode_i`=2'd2 and `trace_i`=1. In any other mode `trace_i` has no effect.
- R6: At an instruction end with `instr_class_i`=2'd2 (return-from-exception), trace is not accepted, but an interrupt can be.
- R7: An interrupt is not accepted at an instruction end with `instr_class_i`=2'd1 (control-flag write). It is also not accepted at the `seq_end_i` that closes reset handling. `instr_class_i` values 0 and 3 are plain instructions.
- R8: `trap_i`=1 while `busy_o`=0 is accepted when no higher source wins. Its vector is 8 + `trap_code_i`.
- R9: An accepted interrupt passes `irq_vec_i` to `vec_o` unchanged.
- R10: `busy_o` rises together with `start_o`. It stays 1 until a `seq_end_i` that accepts nothing. While `busy_o` is 1, instruction ends and traps are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin_i | input | 1 | Synchronized reset pin level, active low; handling starts on its rising edge |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| trace_i | input | 1 | Trace flag |
| int_mode_i | input | 2 | Interrupt control mode |
| irq_i | input | 1 | Masked interrupt request |
| irq_vec_i | input | 8 | Vector number of the pending interrupt |
| instr_end_i | input | 1 | Instruction retired this cycle |
| instr_class_i | input | 2 | Class of the retired instruction (0 plain, 1 control write, 2 return, 3 plain) |
| trap_i | input | 1 | Trap instruction executing |
| trap_code_i | input | 2 | Trap number |
| seq_end_i | input | 1 | Exception handling sequence finished |
| start_o | output | 1 | Vector fetch start pulse |
| accept_o | output | 4 | One-hot accepted exception type |
| vec_o | output | 8 | Vector number |
| busy_o | output | 1 | Handling sequence in progress |

## Verification
Several properties are checked on every cycle. A reset source must produce a reset start on the next clock. The start pulse and the one-hot type must agree. Each type must carry its vector encoding. No trace may appear outside mode 2, and no interrupt may follow a control-flag write. Some behaviours need a sequence of events and are shown only by the bench's scenarios and its cycle model: the ranking when all sources collide, the interrupt block at the close of reset handling, trace suppression after a return, and the release of the busy state.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int N_EXC     = 4;
    localparam int VEC_W     = 8;
    localparam int EX_RST    = 0;
    localparam int EX_TRC    = 1;
    localparam int EX_IRQ    = 2;
    localparam int EX_TRP    = 3;
    localparam logic [1:0] TRACE_MODE = 2'd2;
    localparam logic [VEC_W-1:0] VEC_RESET = '0;
    localparam logic [VEC_W-1:0] VEC_TRACE = VEC_W'(5);
    localparam logic [VEC_W-1:0] VEC_TRAP  = VEC_W'(8);

    typedef enum logic [1:0] {
        IC_PLAIN = 2'd0,
        IC_CTRL  = 2'd1,
        IC_RET   = 2'd2,
        IC_MISC  = 2'd3
    } iclass_e;

    typedef struct packed {
        logic             valid;
        logic [N_EXC-1:0] kind;
        logic [VEC_W-1:0] vec;
    } pick_t;

    // Lowest set index wins (index 0 is highest rank).
    function automatic logic [N_EXC-1:0] first_set(input logic [N_EXC-1:0] req);
        logic [N_EXC-1:0] r;
        logic             seen;
        r    = '0;
        seen = 1'b0;
        for (int i = 0; i < N_EXC; i++) begin
            if (req[i] && !seen) begin
                r[i] = 1'b1;
                seen = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/exc_edge.sv
module exc_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic wdt_i,
    output logic ev_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= pin_i;
    end

    assign ev_o = (pin_i && !pin_q) || wdt_i;
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic             rst_ev_i,
    input  logic             busy_i,
    input  logic             after_rst_i,
    input  logic             instr_end_i,
    input  logic [1:0]       instr_class_i,
    input  logic             trace_i,
    input  logic [1:0]       int_mode_i,
    input  logic             irq_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic             trap_i,
    input  logic [1:0]       trap_code_i,
    input  logic             seq_end_i,
    output logic             seq_done_o,
    output pick_t            pick_o
);
    logic             at_instr, at_seq;
    logic [N_EXC-1:0] req, win;
    logic [VEC_W-1:0] vtab [N_EXC];
    iclass_e          cls;

    assign cls      = iclass_e'(instr_class_i);
    assign at_instr = !busy_i && instr_end_i;
    assign at_seq   = busy_i && seq_end_i;
    assign seq_done_o = at_seq;

    assign req[EX_RST] = rst_ev_i;
    assign req[EX_TRC] = trace_i && (int_mode_i == TRACE_MODE)
                         && ((at_instr && cls != IC_RET) || at_seq);
    assign req[EX_IRQ] = irq_i
                         && ((at_instr && cls != IC_CTRL) || (at_seq && !after_rst_i));
    assign req[EX_TRP] = trap_i && !busy_i;

    assign vtab[EX_RST] = VEC_RESET;
    assign vtab[EX_TRC] = VEC_TRACE;
    assign vtab[EX_IRQ] = irq_vec_i;
    assign vtab[EX_TRP] = VEC_TRAP + VEC_W'(trap_code_i);

    assign win = first_set(req);

    always_comb begin
        pick_o.valid = |req;
        pick_o.kind  = win;
        pick_o.vec   = '0;
        for (int i = 0; i < N_EXC; i++) begin
            if (win[i]) pick_o.vec = vtab[i];
        end
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pick_t            pick_i,
    input  logic             seq_done_i,
    output logic             start_o,
    output logic [N_EXC-1:0] accept_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             busy_o,
    output logic             after_rst_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_o     <= 1'b0;
            accept_o    <= '0;
            vec_o       <= '0;
            busy_o      <= 1'b0;
            after_rst_o <= 1'b0;
        end else begin
            start_o  <= pick_i.valid;
            accept_o <= pick_i.valid ? pick_i.kind : '0;
            if (pick_i.valid) begin
                vec_o       <= pick_i.vec;
                busy_o      <= 1'b1;
                after_rst_o <= pick_i.kind[EX_RST];
            end else if (seq_done_i) begin
                busy_o      <= 1'b0;
                after_rst_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin_i,
    input  logic             wdt_ovf_i,
    input  logic             trace_i,
    input  logic [1:0]       int_mode_i,
    input  logic             irq_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic             instr_end_i,
    input  logic [1:0]       instr_class_i,
    input  logic             trap_i,
    input  logic [1:0]       trap_code_i,
    input  logic             seq_end_i,
    output logic             start_o,
    output logic [N_EXC-1:0] accept_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             busy_o
);
    logic  rst_ev, seq_done, after_rst;
    pick_t pick;

    exc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (rst_pin_i),
        .wdt_i (wdt_ovf_i),
        .ev_o  (rst_ev)
    );

    exc_select u_sel (
        .rst_ev_i      (rst_ev),
        .busy_i        (busy_o),
        .after_rst_i   (after_rst),
        .instr_end_i   (instr_end_i),
        .instr_class_i (instr_class_i),
        .trace_i       (trace_i),
        .int_mode_i    (int_mode_i),
        .irq_i         (irq_i),
        .irq_vec_i     (irq_vec_i),
        .trap_i        (trap_i),
        .trap_code_i   (trap_code_i),
        .seq_end_i     (seq_end_i),
        .seq_done_o    (seq_done),
        .pick_o        (pick)
    );

    exc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .pick_i      (pick),
        .seq_done_i  (seq_done),
        .start_o     (start_o),
        .accept_o    (accept_o),
        .vec_o       (vec_o),
        .busy_o      (busy_o),
        .after_rst_o (after_rst)
    );
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
    import exc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wdt_ovf_i,
    input logic [1:0]       int_mode_i,
    input logic             instr_end_i,
    input logic [1:0]       instr_class_i,
    input logic             start_o,
    input logic [N_EXC-1:0] accept_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             busy_o
);
    p_wdt_reset_r2: assert property (@(posedge clk) disable iff (rst)
        wdt_ovf_i |=> (start_o && accept_o[EX_RST]));

    p_one_type_r3: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ($countones(accept_o) == 1));

    p_quiet_type_r3: assert property (@(posedge clk) disable iff (rst)
        !start_o |-> (accept_o == '0));

    p_trace_mode_r5: assert property (@(posedge clk) disable iff (rst)
        (start_o && accept_o[EX_TRC]) |-> ($past(int_mode_i) == TRACE_MODE));

    p_no_irq_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        (start_o && accept_o[EX_IRQ]) |->
            !($past(instr_end_i) && !$past(busy_o) && $past(instr_class_i) == 2'd1));

    p_trap_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (start_o && accept_o[EX_TRP]) |-> (vec_o[VEC_W-1:2] == VEC_TRAP[VEC_W-1:2]));

    p_fixed_vec_r2: assert property (@(posedge clk) disable iff (rst)
        (start_o && accept_o[EX_RST]) |-> (vec_o == VEC_RESET));

    p_trace_vec_r5: assert property (@(posedge clk) disable iff (rst)
        (start_o && accept_o[EX_TRC]) |-> (vec_o == VEC_TRACE));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);
endmodule

bind exc_arbiter exc_arbiter_chk u_chk (.*);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin_i = 1'b1, wdt_ovf_i = 1'b0, trace_i = 1'b0;
    logic [1:0] int_mode_i = 2'd0;
    logic       irq_i = 1'b0;
    logic [7:0] irq_vec_i = 8'd0;
    logic       instr_end_i = 1'b0;
    logic [1:0] instr_class_i = 2'd0;
    logic       trap_i = 1'b0;
    logic [1:0] trap_code_i = 2'd0;
    logic       seq_end_i = 1'b0;
    logic       start_o, busy_o;
    logic [3:0] accept_o;
    logic [7:0] vec_o;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    // reference state
    bit m_prev = 1'b1, m_busy = 1'b0, m_arst = 1'b0;
    bit e_start; bit [3:0] e_acc; bit [7:0] e_vec;

    always #5 clk = ~clk;

    exc_arbiter uut (.*);

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic predict();
        bit ev, ai, as, trc, irq, trp;
        ev  = (rst_pin_i && !m_prev) || wdt_ovf_i;
        ai  = !m_busy && instr_end_i;
        as  = m_busy && seq_end_i;
        trc = trace_i && int_mode_i == 2'd2 && ((ai && instr_class_i != 2'd2) || as);
        irq = irq_i && ((ai && instr_class_i != 2'd1) || (as && !m_arst));
        trp = trap_i && !m_busy;
        e_start = ev || trc || irq || trp;
        e_acc = ev ? 4'b0001 : trc ? 4'b0010 : irq ? 4'b0100 : trp ? 4'b1000 : 4'b0000;
        if (ev) e_vec = 8'd0;
        else if (trc) e_vec = 8'd5;
        else if (irq) e_vec = irq_vec_i;
        else if (trp) e_vec = 8'd8 + 8'(trap_code_i);
        m_prev = rst_pin_i;
        if (e_start) begin m_busy = 1'b1; m_arst = ev; end
        else if (as) begin m_busy = 1'b0; m_arst = 1'b0; end
    endtask

    // inputs already driven (after a negedge); check after the next posedge
    task automatic step(input string tag);
        predict();
        @(posedge clk); @(negedge clk);
        check({tag, " start"}, start_o == e_start, $sformatf("%0b", start_o), $sformatf("%0b", e_start));
        check({tag, " type"}, accept_o == e_acc, $sformatf("%b", accept_o), $sformatf("%b", e_acc));
        if (e_start)
            check({tag, " vector"}, vec_o == e_vec, $sformatf("%0d", vec_o), $sformatf("%0d", e_vec));
        check({tag, " busy"}, busy_o == m_busy, $sformatf("%0b", busy_o), $sformatf("%0b", m_busy));
    endtask

    task automatic idle();
        rst_pin_i = 1'b1; wdt_ovf_i = 0; trace_i = 0; int_mode_i = 0; irq_i = 0;
        instr_end_i = 0; instr_class_i = 0; trap_i = 0; trap_code_i = 0; seq_end_i = 0;
    endtask

    task automatic close_seq();
        idle(); seq_end_i = 1'b1; step("R10 close");
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check("R1 in reset", !start_o && accept_o == 0 && !busy_o,
              $sformatf("%0b/%b/%0b", start_o, accept_o, busy_o), "0/0000/0");
        rst = 1'b0;
        idle(); step("R1 first cycle");

        // R5: trace ignored outside mode 2
        idle(); trace_i = 1; int_mode_i = 2'd0; instr_end_i = 1; step("R5 mode0 trace ignored");
        idle(); trace_i = 1; int_mode_i = 2'd3; instr_end_i = 1; step("R5 mode3 trace ignored");
        idle(); trace_i = 1; int_mode_i = 2'd2; instr_end_i = 1; step("R5 trace taken");
        close_seq();
        // R4: no boundary, no trace/irq
        idle(); trace_i = 1; int_mode_i = 2'd2; irq_i = 1; step("R4 no boundary");
        // R6: no trace after return, irq still
        idle(); trace_i = 1; int_mode_i = 2'd2; instr_end_i = 1; instr_class_i = 2'd2; step("R6 no trace after return");
        idle(); trace_i = 1; int_mode_i = 2'd2; instr_end_i = 1; instr_class_i = 2'd2;
        irq_i = 1; irq_vec_i = 8'd77; step("R6 R9 irq after return");
        close_seq();
        // R7: no irq after control write
        idle(); irq_i = 1; irq_vec_i = 8'd40; instr_end_i = 1; instr_class_i = 2'd1; step("R7 ctrl write blocks irq");
        // R8 trap vector
        idle(); trap_i = 1; trap_code_i = 2'd3; step("R8 trap code 3");
        // R10: busy blocks instr end and trap
        idle(); irq_i = 1; instr_end_i = 1; trap_i = 1; step("R10 busy blocks");
        close_seq();
        // R2: pin rising edge while busy + R7 after reset
        idle(); trap_i = 1; step("R8 trap");
        idle(); rst_pin_i = 0; step("R2 pin low");
        idle(); step("R2 pin rise");
        idle(); irq_i = 1; irq_vec_i = 8'd33; seq_end_i = 1; step("R7 irq blocked after reset");
        // R3: everything at once
        idle(); wdt_ovf_i = 1; trace_i = 1; int_mode_i = 2'd2; irq_i = 1; instr_end_i = 1; trap_i = 1;
        step("R3 all sources");
        close_seq();
        idle(); trace_i = 1; int_mode_i = 2'd2; irq_i = 1; instr_end_i = 1; trap_i = 1; step("R3 trace over irq");
        close_seq();
        idle(); irq_i = 1; irq_vec_i = 8'd200; instr_end_i = 1; trap_i = 1; step("R3 R9 irq over trap");
        close_seq();

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            rst_pin_i     = ($urandom % 40) != 0;
            wdt_ovf_i     = ($urandom % 60) == 0;
            trace_i       = $urandom % 2;
            int_mode_i    = 2'($urandom);
            irq_i         = ($urandom % 5) < 2;
            irq_vec_i     = 8'($urandom);
            instr_end_i   = ($urandom % 5) < 2;
            instr_class_i = 2'($urandom);
            trap_i        = ($urandom % 10) == 0;
            trap_code_i   = 2'($urandom);
            seq_end_i     = ($urandom % 3) == 0;
            step("R3 R4 R10 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule